// File: doc/BRIEF.md
# Side-Channel Request Bridge to Register Bus and I2C

This block executes requests that arrive one at a time over a display side channel. Each request carries a command, an address, a length and up to sixteen write bytes. Native requests turn into single-byte accesses on an internal register bus that spans a 20-bit address space. I2C-tunnelled requests turn into a series of byte-level operations (start, send, receive, stop) on an I2C master. Each request returns one reply code and, for reads, the bytes it collected.

The block can keep an I2C transaction open between requests. A request flagged as middle-of-transaction (MOT) does not close the bus at its end. A later MOT request continues on the same transaction when it targets the same device address with the same command. It closes and reopens the transaction when the address or the command differs. A request without the flag always runs a complete transaction and closes any transaction left open.

Requests and replies use valid/ready handshakes. Request back-pressure: `req_ready` is high only while the block is idle, and a request is taken in a cycle where `req_valid` and `req_ready` are both high. Reply back-pressure: `rsp_valid` stays high with a stable payload until `rsp_ready` is seen. No new request is taken before then. The register bus and the I2C operation port each hold their request until the matching done pulse arrives.

Top module: `aux_i2c_bridge`

## Requirements
- R1: `req_ready` is high only when no request is in progress and no reply is waiting. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_code` and `rsp_rdata` stay unchanged.
- R2: A native request (command 4'h8 writes, 4'h9 reads) with length N from 1 to 16 issues N register accesses at addresses A, A+1, ... taken modulo 2^20. `reg_we` is high for writes, and write byte i comes from `req_wdata[8i+7:8i]`. Read byte i is returned in `rsp_rdata[8i+7:8i]`, and bytes not read are zero. If every access succeeds, the reply is ACK (2'b00).
- R3: A native access that returns `reg_err` ends the request. No further access is issued, and the reply is NACK (2'b01).
- R4: A native request of length 0 issues no access and replies NACK.
- R5: A plain I2C request (command 4'h0 writes, 4'h1 reads) first issues a stop if a transaction is open. It then issues a start, sends or receives every byte, ends with a stop and replies ACK. Read byte i is placed as in R2. With length 0 it issues only the start and the stop.
- R6: A start that is not acknowledged gives the reply I2C_NACK (2'b11). No data operation and no stop follow it, and the transaction counts as closed.
- R7: A write byte that is not acknowledged ends the data phase. A stop follows, which closes the transaction, and the reply is I2C_NACK. This applies both with and without MOT.
- R8: A MOT request (command 4'h4 writes, 4'h5 reads; bit 2 is the MOT flag) issues a start when no transaction is open. If a transaction is open and the 7-bit device address or the command differs from the stored ones, it issues a stop and then a start. Otherwise it continues with no start. A successful start stores the command and the address.
- R9: A MOT request that completes without a write byte being refused issues no stop and replies ACK. The transaction stays open for the next request.
- R10: Any other command value, or a length above 16, replies NACK with no bus operation and no change to the open-transaction state. `rsp_valid` rises in the cycle after the request is accepted.
- R11: The reply code DEFER (2'b10) is never produced.
- R12: The I2C port presents one operation at a time on `i2c_op` (0 start, 1 send, 2 receive, 3 stop). The operation, `i2c_wdata`, `i2c_addr` and `i2c_rd` are held until `i2c_done`. `i2c_valid` and `reg_req` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_cmd | input | 4 | Command code |
| req_addr | input | 20 | Register address, or I2C device address in bits 6:0 |
| req_len | input | 5 | Byte count |
| req_wdata | input | 128 | Write bytes, byte i in bits 8i+7:8i |
| rsp_valid | output | 1 | Reply available |
| rsp_ready | input | 1 | Reply consumed |
| rsp_code | output | 2 | Reply code |
| rsp_rdata | output | 128 | Read bytes |
| reg_req | output | 1 | Register access pending |
| reg_we | output | 1 | Register access is a write |
| reg_addr | output | 20 | Register address |
| reg_wdata | output | 8 | Register write byte |
| reg_done | input | 1 | Register access complete |
| reg_err | input | 1 | Register access failed |
| reg_rdata | input | 8 | Register read byte |
| i2c_valid | output | 1 | I2C operation pending |
| i2c_op | output | 2 | I2C operation code |
| i2c_rd | output | 1 | Direction bit for a start |
| i2c_addr | output | 7 | Device address for a start |
| i2c_wdata | output | 8 | Byte to send |
| i2c_done | input | 1 | I2C operation complete |
| i2c_nack | input | 1 | Address or byte not acknowledged |
| i2c_rdata | input | 8 | Received byte |

## Verification
A rejected request, or a native request of length 0, must show `rsp_valid` one cycle after acceptance. The bench counts cycles from the accepting edge and checks that this count is exactly one. For all other requests, every bus operation completes in the cycle its done pulse is sampled, and the next operation or the reply follows one cycle later. The bench therefore waits at falling edges for `rsp_valid` and checks `req_ready` low at each of those edges. It then holds `rsp_ready` low for a random number of cycles and checks that the reply stays unchanged. It also compares the full logged sequence of bus operations, the reply code and the read bytes against a bench model of the device and of the open-transaction rules.

// File: rtl/aux_br_pkg.sv
package aux_br_pkg;
  typedef enum logic [1:0] {
    RSP_ACK      = 2'b00,
    RSP_NACK     = 2'b01,
    RSP_DEFER    = 2'b10,
    RSP_I2C_NACK = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } i2c_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_DECIDE, S_PRESTOP, S_START, S_XFER, S_POSTSTOP, S_NATIVE, S_RESP
  } st_e;

  localparam logic [3:0] CMD_I2C_WR = 4'h0;
  localparam logic [3:0] CMD_I2C_RD = 4'h1;
  localparam logic [3:0] CMD_MOT_WR = 4'h4;
  localparam logic [3:0] CMD_MOT_RD = 4'h5;
  localparam logic [3:0] CMD_NAT_WR = 4'h8;
  localparam logic [3:0] CMD_NAT_RD = 4'h9;
  localparam int MOT_BIT = 2;
  localparam int NAT_BIT = 3;
endpackage

// File: rtl/aux_br_decode.sv
module aux_br_decode
  import aux_br_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input  logic [3:0]       cmd,
  input  logic [LEN_W-1:0] len,
  output logic             bad,
  output logic             native,
  output logic             mot,
  output logic             rd,
  output logic             len_zero
);
  logic known;

  always_comb begin
    unique case (cmd)
      CMD_I2C_WR, CMD_I2C_RD, CMD_MOT_WR, CMD_MOT_RD,
      CMD_NAT_WR, CMD_NAT_RD: known = 1'b1;
      default:                known = 1'b0;
    endcase
  end

  assign bad      = !known || (len > LEN_W'(MAX_LEN));
  assign native   = cmd[NAT_BIT];
  assign mot      = cmd[MOT_BIT];
  assign rd       = cmd[0];
  assign len_zero = (len == '0);
endmodule

// File: rtl/aux_br_mot_track.sv
module aux_br_mot_track #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_open,
  input  logic          clr_open,
  input  logic          rec,
  input  logic [3:0]    cmd,
  input  logic [AW-1:0] addr,
  output logic          open,
  output logic          restart
);
  logic [3:0]    last_cmd;
  logic [AW-1:0] last_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open      <= 1'b0;
      last_cmd  <= '0;
      last_addr <= '0;
    end else begin
      if (clr_open)      open <= 1'b0;
      else if (set_open) open <= 1'b1;
      if (rec) begin
        last_cmd  <= cmd;
        last_addr <= addr;
      end
    end
  end

  assign restart = open && ((cmd != last_cmd) || (addr != last_addr));
endmodule

// File: rtl/aux_br_rbuf.sv
module aux_br_rbuf #(
  parameter int MAX_LEN = 16,
  parameter int IDX_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [7:0]           wr_data,
  output logic [8*MAX_LEN-1:0] rdata
);
  for (genvar b = 0; b < MAX_LEN; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n || clr)
        rdata[8*b +: 8] <= '0;
      else if (wr_en && (wr_idx == IDX_W'(b)))
        rdata[8*b +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
  import aux_br_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int I2C_AW  = 7,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1),
  parameter int DATA_W  = 8 * MAX_LEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_cmd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_done,
  input  logic              reg_err,
  input  logic [7:0]        reg_rdata,
  output logic              i2c_valid,
  output logic [1:0]        i2c_op,
  output logic              i2c_rd,
  output logic [I2C_AW-1:0] i2c_addr,
  output logic [7:0]        i2c_wdata,
  input  logic              i2c_done,
  input  logic              i2c_nack,
  input  logic [7:0]        i2c_rdata
);
  localparam int IDX_W = $clog2(MAX_LEN);

  st_e               st;
  rsp_e              code_q;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  idx;

  logic bad, native, mot, rd, len_zero;
  logic open, restart;
  logic op_done, last_byte;
  logic set_open, clr_open, rec;
  logic buf_wr, buf_clr;
  logic [7:0] buf_data, cur_byte;

  aux_br_decode #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dec (
    .cmd(cmd_q), .len(len_q), .bad(bad), .native(native),
    .mot(mot), .rd(rd), .len_zero(len_zero)
  );

  aux_br_mot_track #(.AW(I2C_AW)) u_mot (
    .clk(clk), .rst_n(rst_n), .set_open(set_open), .clr_open(clr_open),
    .rec(rec), .cmd(cmd_q), .addr(addr_q[I2C_AW-1:0]),
    .open(open), .restart(restart)
  );

  aux_br_rbuf #(.MAX_LEN(MAX_LEN), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr),
    .wr_idx(idx), .wr_data(buf_data), .rdata(rsp_rdata)
  );

  assign op_done   = i2c_valid && i2c_done;
  assign last_byte = ({{(LEN_W-IDX_W){1'b0}}, idx} + LEN_W'(1)) == len_q;
  assign cur_byte  = wdata_q[{idx, 3'b000} +: 8];

  assign set_open = (st == S_START) && op_done && !i2c_nack;
  assign clr_open = ((st == S_PRESTOP || st == S_POSTSTOP) && op_done) ||
                    ((st == S_START) && op_done && i2c_nack) ||
                    ((st == S_XFER) && op_done && !rd && i2c_nack);
  assign rec      = set_open && mot;

  assign buf_clr  = (st == S_IDLE) && req_valid;
  assign buf_wr   = rd && (((st == S_XFER) && op_done) ||
                           ((st == S_NATIVE) && reg_done && !reg_err));
  assign buf_data = native ? reg_rdata : i2c_rdata;

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_code  = code_q;

  assign reg_req   = (st == S_NATIVE);
  assign reg_we    = !rd;
  assign reg_addr  = addr_q + ADDR_W'(idx);
  assign reg_wdata = cur_byte;

  assign i2c_valid = (st == S_PRESTOP) || (st == S_START) ||
                     (st == S_XFER) || (st == S_POSTSTOP);
  assign i2c_rd    = rd;
  assign i2c_addr  = addr_q[I2C_AW-1:0];
  assign i2c_wdata = cur_byte;

  always_comb begin
    unique case (st)
      S_START: i2c_op = OP_START;
      S_XFER:  i2c_op = rd ? OP_RECV : OP_SEND;
      default: i2c_op = OP_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      code_q  <= RSP_NACK;
      cmd_q   <= '0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
      idx     <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          cmd_q   <= req_cmd;
          addr_q  <= req_addr;
          len_q   <= req_len;
          wdata_q <= req_wdata;
          idx     <= '0;
          st      <= S_DECIDE;
        end
        S_DECIDE: begin
          idx <= '0;
          if (bad) begin
            code_q <= RSP_NACK;
            st     <= S_RESP;
          end else if (native) begin
            code_q <= RSP_NACK;
            st     <= len_zero ? S_RESP : S_NATIVE;
          end else if (!mot) begin
            st <= open ? S_PRESTOP : S_START;
          end else if (!open) begin
            st <= S_START;
          end else if (restart) begin
            st <= S_PRESTOP;
          end else begin
            code_q <= RSP_ACK;
            st     <= len_zero ? S_RESP : S_XFER;
          end
        end
        S_PRESTOP: if (op_done) st <= S_START;
        S_START: if (op_done) begin
          if (i2c_nack) begin
            code_q <= RSP_I2C_NACK;
            st     <= S_RESP;
          end else begin
            code_q <= RSP_ACK;
            if (len_zero) st <= mot ? S_RESP : S_POSTSTOP;
            else          st <= S_XFER;
          end
        end
        S_XFER: if (op_done) begin
          if (!rd && i2c_nack) begin
            code_q <= RSP_I2C_NACK;
            st     <= S_POSTSTOP;
          end else if (last_byte) begin
            st <= mot ? S_RESP : S_POSTSTOP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_POSTSTOP: if (op_done) st <= S_RESP;
        S_NATIVE: if (reg_done) begin
          if (reg_err) begin
            code_q <= RSP_NACK;
            st     <= S_RESP;
          end else if (last_byte) begin
            code_q <= RSP_ACK;
            st     <= S_RESP;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_br_checker.sv
module aux_br_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 128,
  parameter int I2C_AW = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_code,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              reg_req,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_done,
  input logic              reg_err,
  input logic              i2c_valid,
  input logic [1:0]        i2c_op,
  input logic [7:0]        i2c_wdata,
  input logic [I2C_AW-1:0] i2c_addr,
  input logic              i2c_rd,
  input logic              i2c_done
);
  // R1: never ready while a reply waits
  a_r1_ready_vs_reply: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));

  // R1: reply held under back-pressure
  a_r1_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code) && $stable(rsp_rdata)));

  // R2: consecutive accesses of one request step the address by one
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_done && !reg_err) |=>
      (!reg_req || reg_addr == $past(reg_addr) + ADDR_W'(1)));

  // R3: no access after an error
  a_r3_stop_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_done && reg_err) |=> !reg_req);

  // R11: DEFER never returned
  a_r11_no_defer: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code != 2'b10));

  // R12: operation held until done
  a_r12_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (i2c_valid && !i2c_done) |=>
      (i2c_valid && $stable(i2c_op) && $stable(i2c_wdata) &&
       $stable(i2c_addr) && $stable(i2c_rd)));

  // R12: one bus active at a time
  a_r12_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i2c_valid, reg_req, rsp_valid}));
endmodule

bind aux_i2c_bridge aux_br_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .I2C_AW(I2C_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
  .reg_req(reg_req), .reg_addr(reg_addr), .reg_done(reg_done), .reg_err(reg_err),
  .i2c_valid(i2c_valid), .i2c_op(i2c_op), .i2c_wdata(i2c_wdata),
  .i2c_addr(i2c_addr), .i2c_rd(i2c_rd), .i2c_done(i2c_done)
);

// File: tb/sim_aux_i2c_bridge.sv
`timescale 1ns/1ps
module sim_aux_i2c_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         req_valid = 1'b0, req_ready;
  logic [3:0]   req_cmd = '0;
  logic [19:0]  req_addr = '0;
  logic [4:0]   req_len = '0;
  logic [127:0] req_wdata = '0;
  logic         rsp_valid, rsp_ready = 1'b0;
  logic [1:0]   rsp_code;
  logic [127:0] rsp_rdata;
  logic         reg_req, reg_we, reg_done = 1'b0, reg_err = 1'b0;
  logic [19:0]  reg_addr;
  logic [7:0]   reg_wdata, reg_rdata = '0;
  logic         i2c_valid, i2c_rd, i2c_done = 1'b0, i2c_nack = 1'b0;
  logic [1:0]   i2c_op;
  logic [6:0]   i2c_addr;
  logic [7:0]   i2c_wdata, i2c_rdata = '0;

  aux_i2c_bridge u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_done(reg_done), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .i2c_valid(i2c_valid), .i2c_op(i2c_op), .i2c_rd(i2c_rd), .i2c_addr(i2c_addr),
    .i2c_wdata(i2c_wdata), .i2c_done(i2c_done), .i2c_nack(i2c_nack), .i2c_rdata(i2c_rdata)
  );

  int tests = 0, fails = 0;

  // event kinds in the log
  localparam logic [3:0] E_START = 4'd1, E_SEND = 4'd2, E_RECV = 4'd3,
                         E_STOP = 4'd4, E_REGW = 4'd5, E_REGR = 4'd6;
  logic [31:0] ev_log [64];
  logic [31:0] exp_ev [64];
  int ev_n = 0, exp_n = 0;

  function automatic logic dev_ack(input logic [6:0] a);
    return (a == 7'h50) || (a == 7'h51);
  endfunction
  function automatic logic [7:0] dev_byte(input logic [6:0] a, input int c);
    return {a[3:0], 4'(c)} ^ 8'h5A;
  endfunction
  function automatic logic reg_bad(input logic [19:0] a);
    return a[19:16] == 4'hA;
  endfunction
  function automatic logic [7:0] reg_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction
  function automatic logic [31:0] ev(input logic [3:0] k, input logic [27:0] p);
    return {k, p};
  endfunction

  // device responders
  logic [6:0] dev_cur = '0;
  int dev_cnt = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (i2c_valid && !i2c_done) begin
        i2c_done = 1'b1;
        i2c_nack = 1'b0;
        case (i2c_op)
          2'd0: begin
            i2c_nack = !dev_ack(i2c_addr);
            dev_cur = i2c_addr; dev_cnt = 0;
            ev_log[ev_n] = ev(E_START, {20'h0, i2c_rd, i2c_addr});
          end
          2'd1: begin
            i2c_nack = (i2c_wdata == 8'hEE);
            ev_log[ev_n] = ev(E_SEND, {20'h0, i2c_wdata});
          end
          2'd2: begin
            i2c_rdata = dev_byte(dev_cur, dev_cnt); dev_cnt++;
            ev_log[ev_n] = ev(E_RECV, 28'h0);
          end
          default: ev_log[ev_n] = ev(E_STOP, 28'h0);
        endcase
        if (ev_n < 63) ev_n++;
      end else begin
        i2c_done = 1'b0;
      end
      if (reg_req && !reg_done) begin
        reg_done = 1'b1;
        reg_err = reg_bad(reg_addr);
        reg_rdata = reg_byte(reg_addr);
        ev_log[ev_n] = reg_we ? ev(E_REGW, {reg_addr, reg_wdata}) : ev(E_REGR, {reg_addr, 8'h0});
        if (ev_n < 63) ev_n++;
      end else begin
        reg_done = 1'b0;
      end
    end
  end

  // reference model state
  logic       m_open = 1'b0;
  logic [3:0] m_cmd = '0;
  logic [6:0] m_addr = '0;
  int         m_cnt = 0;
  logic [6:0] m_dev = '0;
  logic [1:0]   exp_code;
  logic [127:0] exp_rd;

  task automatic push(input logic [31:0] e);
    exp_ev[exp_n] = e;
    if (exp_n < 63) exp_n++;
  endtask

  task automatic m_start(input logic rd, input logic [6:0] a7, output logic ok);
    push(ev(E_START, {20'h0, rd, a7}));
    m_dev = a7; m_cnt = 0;
    ok = dev_ack(a7);
    m_open = ok;
  endtask

  task automatic model(input logic [3:0] c, input logic [19:0] a, input logic [4:0] n,
                       input logic [127:0] wd);
    logic ok;
    logic [6:0] a7;
    logic [19:0] ra;
    a7 = a[6:0];
    exp_n = 0; exp_rd = '0; exp_code = 2'b01;
    if (!(c inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9}) || n > 16) begin
      exp_code = 2'b01;
    end else if (c[3]) begin
      for (int i = 0; i < n; i++) begin
        ra = a + 20'(i);
        push(c[0] ? ev(E_REGR, {ra, 8'h0}) : ev(E_REGW, {ra, wd[8*i +: 8]}));
        if (reg_bad(ra)) begin exp_code = 2'b01; break; end
        if (c[0]) exp_rd[8*i +: 8] = reg_byte(ra);
        exp_code = 2'b00;
      end
    end else begin
      ok = 1'b1;
      if (!c[2]) begin
        if (m_open) begin push(ev(E_STOP, 28'h0)); m_open = 1'b0; end
        m_start(c[0], a7, ok);
      end else if (!m_open) begin
        m_start(c[0], a7, ok);
      end else if (a7 != m_addr || c != m_cmd) begin
        push(ev(E_STOP, 28'h0)); m_open = 1'b0;
        m_start(c[0], a7, ok);
      end
      if (!ok) begin
        exp_code = 2'b11;
      end else begin
        if (c[2]) begin m_cmd = c; m_addr = a7; end
        exp_code = 2'b00;
        for (int i = 0; i < n; i++) begin
          if (c[0]) begin
            push(ev(E_RECV, 28'h0));
            exp_rd[8*i +: 8] = dev_byte(m_dev, m_cnt); m_cnt++;
          end else begin
            push(ev(E_SEND, {20'h0, wd[8*i +: 8]}));
            if (wd[8*i +: 8] == 8'hEE) begin
              exp_code = 2'b11;
              if (c[2]) begin push(ev(E_STOP, 28'h0)); m_open = 1'b0; end
              break;
            end
          end
        end
        if (!c[2]) begin push(ev(E_STOP, 28'h0)); m_open = 1'b0; end
      end
    end
  endtask

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic do_req(input logic [3:0] c, input logic [19:0] a, input logic [4:0] n,
                        input logic [127:0] wd);
    string tag;
    int lat, bp;
    logic [1:0] hold_code;
    logic [127:0] hold_rd;
    logic bad, busy_ok, hold_ok;
    bad = !(c inside {4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9}) || n > 16;
    if (bad) tag = "R10";
    else if (c[3]) tag = (n == 0) ? "R4" : "R2/R3";
    else if (c[2]) tag = "R8/R9";
    else tag = "R5/R6/R7";
    model(c, a, n, wd);
    ev_n = 0;
    req_cmd = c; req_addr = a; req_len = n; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy_ok = !req_ready;
    lat = 0;
    while (!rsp_valid) begin
      @(negedge clk); lat++;
      if (!rsp_valid && req_ready) busy_ok = 1'b0;
    end
    chk(busy_ok, "R1", "ready while busy", 128'(req_ready), 128'(0));
    if (bad || (c[3] && n == 0))
      chk(lat == 1, bad ? "R10" : "R4", "reply latency", 128'(lat), 128'(1));
    chk(rsp_code == exp_code, tag, "reply code", 128'(rsp_code), 128'(exp_code));
    chk(rsp_code != 2'b10, "R11", "defer code", 128'(rsp_code), 128'(0));
    chk(rsp_rdata == exp_rd, tag, "read data", rsp_rdata, exp_rd);
    chk(ev_n == exp_n, tag, "bus op count", 128'(ev_n), 128'(exp_n));
    for (int i = 0; i < exp_n && i < ev_n; i++) begin
      if (ev_log[i] != exp_ev[i]) begin
        chk(1'b0, tag, $sformatf("bus op %0d", i), 128'(ev_log[i]), 128'(exp_ev[i]));
        break;
      end
    end
    hold_code = rsp_code; hold_rd = rsp_rdata; hold_ok = 1'b1;
    bp = $urandom % 4;
    for (int i = 0; i < bp; i++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_code != hold_code || rsp_rdata != hold_rd) hold_ok = 1'b0;
    end
    if (bp > 0) chk(hold_ok, "R1", "reply held", 128'(rsp_code), 128'(hold_code));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  function automatic logic [127:0] rnd_data();
    logic [127:0] d;
    for (int i = 0; i < 16; i++) begin
      d[8*i +: 8] = 8'($urandom);
      if ($urandom % 10 == 0) d[8*i +: 8] = 8'hEE;
    end
    return d;
  endfunction

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  localparam logic [3:0] BADC [8] = '{4'h2, 4'h3, 4'h6, 4'h7, 4'hA, 4'hB, 4'hC, 4'hF};
  localparam logic [3:0] GOODC [6] = '{4'h0, 4'h1, 4'h4, 4'h5, 4'h8, 4'h9};
  localparam logic [6:0] DEVS [3] = '{7'h50, 7'h51, 7'h23};

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !i2c_valid && !reg_req, "R1", "reset state",
        128'({req_ready, rsp_valid, i2c_valid, reg_req}), 128'(4'b1000));

    // directed corners
    do_req(4'h4, 20'h00050, 5'd2, 128'h0201);   // R8 first start
    do_req(4'h4, 20'h00050, 5'd1, 128'h03);     // R9 continue, no start
    do_req(4'h5, 20'h00050, 5'd2, 128'h0);      // R8 command change restarts
    do_req(4'h5, 20'h00051, 5'd3, 128'h0);      // R8 address change restarts
    do_req(4'h5, 20'h00051, 5'd1, 128'h0);      // R9 continue read
    do_req(4'h2, 20'h00051, 5'd1, 128'h0);      // R10 no effect on open state
    do_req(4'h5, 20'h00051, 5'd1, 128'h0);      // still continues
    do_req(4'h0, 20'h00050, 5'd2, 128'h1122);   // R5 stop first
    do_req(4'h8, 20'h12345, 5'd0, 128'h0);      // R4
    do_req(4'h9, 20'hFFFFE, 5'd4, 128'h0);      // R2 wrap
    do_req(4'h9, 20'h9FFFE, 5'd4, 128'h0);      // R3 error mid-way
    do_req(4'h4, 20'h00050, 5'd3, 128'h33EE11); // R7 MOT byte refused
    do_req(4'h1, 20'h00023, 5'd2, 128'h0);      // R6 start refused
    do_req(4'h9, 20'h00010, 5'd17, 128'h0);     // R10 too long
    do_req(4'h0, 20'h00050, 5'd0, 128'h0);      // R5 zero length

    for (int k = 0; k < 300; k++) begin
      logic [3:0] c;
      logic [19:0] a;
      logic [4:0] n;
      if ($urandom % 8 == 0) c = BADC[$urandom % 8];
      else c = GOODC[$urandom % 6];
      if (c[3]) begin
        case ($urandom % 4)
          0: a = 20'hA0000 + 20'($urandom % 32);
          1: a = 20'hFFFF0 + 20'($urandom % 16);
          default: a = 20'($urandom);
        endcase
      end else begin
        a = {13'($urandom), DEVS[$urandom % 3]};
      end
      n = ($urandom % 6 == 0) ? 5'($urandom % 18) : 5'(1 + $urandom % 4);
      do_req(c, a, n, rnd_data());
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule